// File: doc/BRIEF.md
# Per-Port Receive Statistics Bank

This block keeps a set of traffic counters for each receive port of a packet front end. For every received frame, upstream logic presents a one-cycle summary: the port number, the frame length in bytes (FCS bytes included), and flags for FCS error, multicast, broadcast, inbound error and drop. From one summary the block updates every counter that the frame touches, in a single clock edge. These counters include the packet and octet totals, a seven-bucket size histogram, short-frame and long-frame counts split by FCS status, multicast and broadcast counts, drop counts and inbound good/error counts.

Software or a collector reads the counters through a registered read port, addressed by port and counter index. A global control input turns every read into a read-and-clear. If a frame updates the counter being cleared in the same cycle, that update is kept. All counters saturate at their all-ones value.

Top module: `rxstat_bank`

## Requirements
- R1: After reset every counter of every port reads 0 and `rd_valid` is low.
- R2: Each summary adds 1 to the packet total (index 0) and adds the length to the octet total (index 1) and to the inbound octet total (index 18, OCT_W bits wide, default 64).
- R3: A frame from 64 to MAX_LEN bytes adds 1 to exactly one histogram bucket: 64 exactly (index 6), 65-127 (7), 128-255 (8), 256-511 (9), 512-1023 (10), 1024-1518 (11), 1519-MAX_LEN (12).
- R4: A frame shorter than MIN_LEN adds 1 to index 13 if its FCS is good and to index 14 if its FCS is bad. A frame longer than MAX_LEN adds 1 to index 15 if its FCS is good and to index 16 if its FCS is bad. Neither kind enters the histogram.
- R5: A frame flagged broadcast adds 1 to index 5 only. A frame flagged multicast and not broadcast adds 1 to index 4.
- R6: A frame flagged for dropping adds 1 to the dropped-packet count (index 2) and its length to the dropped-octet count (index 3).
- R7: A frame with the inbound-error flag adds 1 to the inbound error count (index 19, ERR_W bits, default 16). Any other frame adds 1 to the inbound good-packet count (index 17).
- R8: A counter never wraps. It holds at its all-ones value once it gets there.
- R9: A read request (`rd_en`) returns the addressed counter on `rd_data`, with `rd_valid` high, one cycle later. The value is the one held before that cycle's update. An index of 20 or more, or an absent port, reads 0.
- R10: With `clr_on_read` high, a read returns the value and resets that counter to 0. With it low, a read leaves the counter unchanged.
- R11: When a clearing read and a frame update hit the same counter in one cycle, the counter ends up holding just that frame's increment.
- R12: A frame changes only the counters of the port it names.
- R13: Counters other than indices 18 and 19 are CNT_W bits wide (default 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_valid | input | 1 | Frame summary present this cycle |
| stat_port | input | PORT_W | Port the frame arrived on |
| stat_len | input | LEN_W | Frame length in bytes, FCS included |
| stat_fcs_err | input | 1 | Frame has a bad FCS |
| stat_mcast | input | 1 | Frame has a multicast destination |
| stat_bcast | input | 1 | Frame has a broadcast destination |
| stat_in_err | input | 1 | Frame carries an inbound error |
| stat_drop | input | 1 | Frame is marked for dropping |
| clr_on_read | input | 1 | Global read-and-clear mode |
| rd_en | input | 1 | Read request |
| rd_port | input | PORT_W | Port to read |
| rd_idx | input | 5 | Counter index to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | OCT_W | Read counter value, zero-extended |

## Verification
The bench builds the bank with two ports, a 14-bit length field and a 4-bit inbound error counter, and keeps MIN_LEN at 64 and MAX_LEN at 1536. The narrow error counter means saturation can be reached with a few dozen frames and checked against an independent model. With two ports, every scenario can also check that the port it did not touch stays unchanged. The 1536-byte maximum leaves room in the top histogram bucket between 1519 and the oversize threshold, so both sides of that boundary are exercised.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int NCNT  = 20;
  localparam int IDX_W = 5;

  localparam int C_PKTS      = 0;
  localparam int C_OCTS      = 1;
  localparam int C_DROP_PKTS = 2;
  localparam int C_DROP_OCTS = 3;
  localparam int C_MCAST     = 4;
  localparam int C_BCAST     = 5;
  localparam int C_H64       = 6;
  localparam int C_H65       = 7;
  localparam int C_H128      = 8;
  localparam int C_H256      = 9;
  localparam int C_H512      = 10;
  localparam int C_H1024     = 11;
  localparam int C_H1519     = 12;
  localparam int C_SHORT     = 13;
  localparam int C_SHORT_BAD = 14;
  localparam int C_LONG      = 15;
  localparam int C_LONG_BAD  = 16;
  localparam int C_INB_PKTS  = 17;
  localparam int C_INB_OCTS  = 18;
  localparam int C_INB_ERRS  = 19;

  function automatic int cnt_width(int idx, int cw, int ew, int ow);
    if (idx == C_INB_OCTS) return ow;
    if (idx == C_INB_ERRS) return ew;
    return cw;
  endfunction
endpackage

// File: rtl/rxstat_classify.sv
module rxstat_classify #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1536
) (
  input  logic [LEN_W-1:0] len,
  input  logic             fcs_err,
  input  logic             mcast,
  input  logic             bcast,
  input  logic             in_err,
  input  logic             drop,
  output logic [rxstat_pkg::NCNT-1:0][LEN_W-1:0] amt
);
  import rxstat_pkg::*;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  always_comb begin
    amt = '0;
    amt[C_PKTS]     = ONE;
    amt[C_OCTS]     = len;
    amt[C_INB_OCTS] = len;
    if (drop) begin
      amt[C_DROP_PKTS] = ONE;
      amt[C_DROP_OCTS] = len;
    end
    // broadcast takes precedence so the two counts never overlap
    if (bcast)      amt[C_BCAST] = ONE;
    else if (mcast) amt[C_MCAST] = ONE;
    if (in_err) amt[C_INB_ERRS] = ONE;
    else        amt[C_INB_PKTS] = ONE;
    if (len < LEN_W'(MIN_LEN)) begin
      if (fcs_err) amt[C_SHORT_BAD] = ONE;
      else         amt[C_SHORT]     = ONE;
    end else if (len > LEN_W'(MAX_LEN)) begin
      if (fcs_err) amt[C_LONG_BAD] = ONE;
      else         amt[C_LONG]     = ONE;
    end
    if (len >= LEN_W'(64) && len <= LEN_W'(MAX_LEN)) begin
      if (len == LEN_W'(64))        amt[C_H64]   = ONE;
      else if (len <= LEN_W'(127))  amt[C_H65]   = ONE;
      else if (len <= LEN_W'(255))  amt[C_H128]  = ONE;
      else if (len <= LEN_W'(511))  amt[C_H256]  = ONE;
      else if (len <= LEN_W'(1023)) amt[C_H512]  = ONE;
      else if (len <= LEN_W'(1518)) amt[C_H1024] = ONE;
      else                          amt[C_H1519] = ONE;
    end
  end
endmodule

// File: rtl/rxstat_cell.sv
module rxstat_cell #(
  parameter int W     = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic             clr,
  input  logic [LEN_W-1:0] add,
  output logic [W-1:0]     value
);
  localparam int SW = ((W > LEN_W) ? W : LEN_W) + 1;
  localparam logic [SW-1:0] TOP = SW'({W{1'b1}});

  logic [SW-1:0] base;
  logic [SW-1:0] sum;

  always_comb begin
    base = clr ? '0 : SW'(value);
    sum  = base + (inc_en ? SW'(add) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst)              value <= '0;
    else if (inc_en || clr) value <= (sum > TOP) ? {W{1'b1}} : W'(sum);
  end
endmodule

// File: rtl/rxstat_bank.sv
module rxstat_bank #(
  parameter int NPORTS  = 4,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1536,
  parameter int CNT_W   = 32,
  parameter int ERR_W   = 16,
  parameter int OCT_W   = 64,
  localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          stat_valid,
  input  logic [PORT_W-1:0]             stat_port,
  input  logic [LEN_W-1:0]              stat_len,
  input  logic                          stat_fcs_err,
  input  logic                          stat_mcast,
  input  logic                          stat_bcast,
  input  logic                          stat_in_err,
  input  logic                          stat_drop,
  input  logic                          clr_on_read,
  input  logic                          rd_en,
  input  logic [PORT_W-1:0]             rd_port,
  input  logic [rxstat_pkg::IDX_W-1:0]  rd_idx,
  output logic                          rd_valid,
  output logic [OCT_W-1:0]              rd_data
);
  import rxstat_pkg::*;

  logic [NCNT-1:0][LEN_W-1:0] inc_amt;
  logic [OCT_W-1:0] cval [NPORTS][NCNT];

  rxstat_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cls (
    .len(stat_len), .fcs_err(stat_fcs_err), .mcast(stat_mcast), .bcast(stat_bcast),
    .in_err(stat_in_err), .drop(stat_drop), .amt(inc_amt)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic hit;
    assign hit = stat_valid && (stat_port == PORT_W'(p));
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      localparam int W = cnt_width(c, CNT_W, ERR_W, OCT_W);
      logic [W-1:0] v;
      logic clr;
      assign clr = rd_en && clr_on_read && (rd_port == PORT_W'(p)) && (rd_idx == IDX_W'(c));
      rxstat_cell #(.W(W), .LEN_W(LEN_W)) u_cell (
        .clk(clk), .rst(rst), .inc_en(hit && (inc_amt[c] != '0)), .clr(clr),
        .add(inc_amt[c]), .value(v)
      );
      assign cval[p][c] = OCT_W'(v);
    end
  end

  logic [OCT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPORTS; p++)
      for (int c = 0; c < NCNT; c++)
        if (rd_port == PORT_W'(p) && rd_idx == IDX_W'(c)) rd_mux = cval[p][c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/rxstat_bank_chk.sv
module rxstat_bank_chk #(
  parameter int LEN_W = 16,
  parameter int ERR_W = 16,
  parameter int OCT_W = 64
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                stat_valid,
  input logic                                stat_bcast,
  input logic                                rd_en,
  input logic [rxstat_pkg::IDX_W-1:0]        rd_idx,
  input logic                                rd_valid,
  input logic [OCT_W-1:0]                    rd_data,
  input logic [rxstat_pkg::NCNT-1:0][LEN_W-1:0] inc_amt
);
  import rxstat_pkg::*;
  localparam logic [OCT_W-1:0] ERR_MAX = OCT_W'((65'(1) << ERR_W) - 65'(1));

  logic [6:0] hist_hit;
  logic [3:0] size_err_hit;
  always_comb begin
    for (int i = 0; i < 7; i++) hist_hit[i] = (inc_amt[C_H64 + i] != '0);
    for (int i = 0; i < 4; i++) size_err_hit[i] = (inc_amt[C_SHORT + i] != '0);
  end

  // R5
  bcast_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_bcast) |-> (inc_amt[C_MCAST] == '0));
  // R3
  hist_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $onehot0(hist_hit));
  // R4
  size_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> ($onehot0(size_err_hit) && !((size_err_hit != 4'd0) && (hist_hit != 7'd0))));
  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R9
  rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
  // R8
  err_width_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_idx) == IDX_W'(C_INB_ERRS)) |-> (rd_data <= ERR_MAX));
endmodule

bind rxstat_bank rxstat_bank_chk #(.LEN_W(LEN_W), .ERR_W(ERR_W), .OCT_W(OCT_W)) u_chk (
  .clk(clk), .rst(rst), .stat_valid(stat_valid), .stat_bcast(stat_bcast),
  .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
  .inc_amt(inc_amt)
);

// File: tb/rxstat_bank_tb.sv
module rxstat_bank_tb;
  localparam int NP = 2, LW = 14, EW = 4, CW = 32, OW = 64;

  logic clk = 0, rst = 1;
  logic stat_valid = 0, stat_fcs_err = 0, stat_mcast = 0, stat_bcast = 0;
  logic stat_in_err = 0, stat_drop = 0, clr_on_read = 0, rd_en = 0;
  logic [0:0] stat_port = 0, rd_port = 0;
  logic [LW-1:0] stat_len = 0;
  logic [4:0] rd_idx = 0;
  logic rd_valid;
  logic [OW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  longint unsigned expv [NP][20];

  always #10 clk = ~clk;

  rxstat_bank #(.NPORTS(NP), .LEN_W(LW), .MIN_LEN(64), .MAX_LEN(1536),
                .CNT_W(CW), .ERR_W(EW), .OCT_W(OW)) u_dut (
    .clk(clk), .rst(rst), .stat_valid(stat_valid), .stat_port(stat_port),
    .stat_len(stat_len), .stat_fcs_err(stat_fcs_err), .stat_mcast(stat_mcast),
    .stat_bcast(stat_bcast), .stat_in_err(stat_in_err), .stat_drop(stat_drop),
    .clr_on_read(clr_on_read), .rd_en(rd_en), .rd_port(rd_port), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic int wid(int i);
    return (i == 18) ? OW : (i == 19) ? EW : CW;
  endfunction

  function automatic longint unsigned sat_add(longint unsigned v, longint unsigned a, int w);
    longint unsigned s = v + a;
    longint unsigned mx = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 1);
    if (w == 64) return (s < v) ? mx : s;
    return (s > mx) ? mx : s;
  endfunction

  task automatic model(int p, int len, bit fcs, bit mc, bit bc, bit ie, bit dr);
    int hb;
    expv[p][0] = sat_add(expv[p][0], 1, wid(0));
    expv[p][1] = sat_add(expv[p][1], len, wid(1));
    expv[p][18] = sat_add(expv[p][18], len, wid(18));
    if (dr) begin
      expv[p][2] = sat_add(expv[p][2], 1, wid(2));
      expv[p][3] = sat_add(expv[p][3], len, wid(3));
    end
    if (bc) expv[p][5] = sat_add(expv[p][5], 1, wid(5));
    else if (mc) expv[p][4] = sat_add(expv[p][4], 1, wid(4));
    if (ie) expv[p][19] = sat_add(expv[p][19], 1, wid(19));
    else    expv[p][17] = sat_add(expv[p][17], 1, wid(17));
    hb = -1;
    if (len < 64) hb = fcs ? 14 : 13;
    else if (len > 1536) hb = fcs ? 16 : 15;
    else if (len == 64) hb = 6;
    else if (len < 128) hb = 7;
    else if (len < 256) hb = 8;
    else if (len < 512) hb = 9;
    else if (len < 1024) hb = 10;
    else if (len < 1519) hb = 11;
    else hb = 12;
    expv[p][hb] = sat_add(expv[p][hb], 1, wid(hb));
  endtask

  task automatic send(int p, int len, bit fcs = 0, bit mc = 0, bit bc = 0, bit ie = 0, bit dr = 0);
    @(negedge clk);
    stat_valid = 1; stat_port = 1'(p); stat_len = LW'(len); stat_fcs_err = fcs;
    stat_mcast = mc; stat_bcast = bc; stat_in_err = ie; stat_drop = dr;
    @(negedge clk);
    stat_valid = 0;
    model(p, len, fcs, mc, bc, ie, dr);
  endtask

  task automatic rd(int p, int idx, output longint unsigned val);
    @(negedge clk);
    rd_en = 1; rd_port = 1'(p); rd_idx = 5'(idx);
    @(negedge clk);
    rd_en = 0;
    val = rd_data;
    if (!rd_valid) begin
      n_fail++;
      $display("FAIL R9: rd_valid actual 0 expected 1 (port %0d idx %0d)", p, idx);
    end
  endtask

  task automatic check(string req, string what, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_port(int p, string req);
    longint unsigned v;
    for (int i = 0; i < 20; i++) begin
      rd(p, i, v);
      check(req, $sformatf("port %0d counter %0d", p, i), v, expv[p][i]);
    end
  endtask

  task automatic t_reset();
    check("R1", "rd_valid after reset", 64'(rd_valid), 0);
    check_port(0, "R1");
    check_port(1, "R1");
  endtask

  task automatic t_hist();
    send(0, 64);  send(0, 100); send(0, 127); send(0, 128); send(0, 300);
    send(0, 600); send(0, 1200); send(0, 1518); send(0, 1519); send(0, 1536);
    check_port(0, "R3");
    check_port(1, "R12");
  endtask

  task automatic t_size_err();
    send(1, 40); send(1, 63, 1); send(1, 63, 1); send(1, 1537); send(1, 2000, 1);
    send(1, 64, 1);
    check_port(1, "R4");
    check_port(0, "R12");
  endtask

  task automatic t_cast();
    send(1, 80, 0, 1, 0); send(1, 80, 0, 0, 1); send(1, 80, 0, 1, 1); send(1, 80, 0, 1, 0);
    check_port(1, "R5");
  endtask

  task automatic t_drop();
    send(0, 500, 0, 0, 0, 0, 1); send(0, 70, 0, 0, 0, 0, 1); send(0, 90);
    check_port(0, "R6");
    check_port(0, "R2");
  endtask

  task automatic t_inerr();
    send(0, 100, 0, 0, 0, 1); send(0, 100, 0, 0, 0, 1); send(0, 100);
    check_port(0, "R7");
  endtask

  task automatic t_sat();
    for (int i = 0; i < 18; i++) send(1, 65, 0, 0, 0, 1);
    check_port(1, "R8");
    check_port(1, "R13");
  endtask

  task automatic t_read_port();
    longint unsigned v;
    rd(0, 25, v);
    check("R9", "index 25 reads zero", v, 0);
    rd(1, 20, v);
    check("R9", "index 20 reads zero", v, 0);
    rd(0, 0, v);
    check("R9", "repeat read without clear", v, expv[0][0]);
  endtask

  task automatic t_clear();
    longint unsigned v;
    clr_on_read = 1;
    rd(0, 1, v);
    check("R10", "clearing read returns value", v, expv[0][1]);
    expv[0][1] = 0;
    rd(0, 1, v);
    check("R10", "counter zero after clearing read", v, 0);
    clr_on_read = 0;
    rd(0, 0, v);
    rd(0, 0, v);
    check("R10", "plain read leaves counter", v, expv[0][0]);
    check_port(0, "R10");
  endtask

  task automatic t_same();
    longint unsigned v;
    clr_on_read = 1;
    @(negedge clk);
    stat_valid = 1; stat_port = 0; stat_len = LW'(200); stat_fcs_err = 0;
    stat_mcast = 0; stat_bcast = 0; stat_in_err = 0; stat_drop = 0;
    rd_en = 1; rd_port = 0; rd_idx = 5'd1;
    @(negedge clk);
    stat_valid = 0; rd_en = 0;
    clr_on_read = 0;
    check("R11", "clear+update read returns old", 64'(rd_data), expv[0][1]);
    model(0, 200, 0, 0, 0, 0, 0);
    expv[0][1] = 200;
    rd(0, 1, v);
    check("R11", "counter holds only new increment", v, 200);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int p = 0; p < NP; p++) for (int i = 0; i < 20; i++) expv[p][i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_hist();
    t_size_err();
    t_cast();
    t_drop();
    t_inerr();
    t_sat();
    t_read_port();
    t_clear();
    t_same();
    check_port(0, "R12");
    check_port(1, "R12");
    finish_up();
  end
endmodule